// File: doc/BRIEF.md
# Dual-Slot Receive Frame Assembler

This block takes the payload bytes of an incoming Ethernet frame, one byte per valid cycle and marked with first and last flags, and rebuilds the full wire image in one of two receive buffers. The image has a seven-byte preamble and a start delimiter, then the payload, zero padding up to the minimum payload size, and a 4-byte frame check sequence. Each buffer is written through its own byte write port. Two small register pairs hand the buffers back and forth between hardware and software. Each pair holds a slot state and the byte count of the stored frame.

Software marks a slot as loaded when the buffer is free for hardware. When a frame starts, the block picks a loaded slot and writes the frame into that buffer. It then stores the byte count and moves the slot to pending. A level interrupt stays high while any slot is pending. Software consumes the buffer and writes the state back to loaded or empty. A ready output tells the upstream source when a frame can be taken.

Top module: `rx_frame_assembler`

## Requirements
- R1: After reset both slot states and both counts read as zero, and rxIrq and rxReady are low.
- R2: The slot state encoding is 0 = empty, 1 = loaded, 2 = pending. It lives in bits [1:0] at register address 0 for slot 0 and address 2 for slot 1. The counts are at address 1 (slot 0) and address 3 (slot 1). A frame goes to slot 0 if slot 0 is loaded, otherwise to slot 1 if slot 1 is loaded. The other slot's registers are left unchanged.
- R3: A frame whose first byte arrives while rxReady is low is dropped entirely. No buffer write is made and no register changes.
- R4: Buffer bytes 0 to 6 hold 0x55, byte 7 holds 0xD5, and the payload is stored from byte 8 onward.
- R5: A payload shorter than 60 bytes is followed by zero bytes up to a padded length of 60. A payload of 60 bytes or more is not padded.
- R6: The 4 bytes after the padded payload hold the CRC-32 of the padded payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, a start value of all ones and a final inversion.
- R7: After all frame bytes are written, the slot count becomes the padded payload length plus 12 and the slot state becomes 2.
- R8: A payload for which length plus 12 would exceed the 2048-byte buffer leaves that slot's state and count unchanged. A payload of exactly 2036 bytes is accepted with count 2048.
- R9: rxIrq is high exactly while either slot state is 2. It follows a software state write from the next cycle.
- R10: rxReady is high only while the block is idle and at least one slot is loaded. It is low while a frame is being assembled.
- R11: Writes go only to the write port of the selected slot, and the two ports never write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload byte valid |
| inFirst | input | 1 | First byte of a frame |
| inLast | input | 1 | Last byte of a frame |
| inData | input | 8 | Payload byte |
| buf0WrEn | output | 1 | Slot 0 buffer write enable |
| buf0Addr | output | 11 | Slot 0 buffer byte address |
| buf0Data | output | 8 | Slot 0 buffer write byte |
| buf1WrEn | output | 1 | Slot 1 buffer write enable |
| buf1Addr | output | 11 | Slot 1 buffer byte address |
| buf1Data | output | 8 | Slot 1 buffer write byte |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| rxIrq | output | 1 | Receive interrupt level |
| rxReady | output | 1 | Ready for a new frame |

## Verification
Frames of 1, 20, 60, 100, 2036 and 2037 payload bytes are sent, with idle gaps inside each frame.
- The 1- and 20-byte frames separate the padding path from the plain payload path.
- The 60-byte frame shows that a payload at the minimum size gets no padding.
- The 2036- and 2037-byte frames sit on either side of the buffer limit.

A scoreboard rebuilds every frame image, including its CRC, and compares it byte for byte against the writes seen on the chosen port.

Slot patterns are also varied:
- both slots empty;
- only slot 1 loaded;
- both slots loaded;
- both slots pending.

Together these show the slot priority and the drop rule. Clearing the two pending states one after the other shows that the interrupt holds while either slot is still pending.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  localparam logic [1:0] SLOT_EMPTY   = 2'd0;
  localparam logic [1:0] SLOT_LOADED  = 2'd1;
  localparam logic [1:0] SLOT_PENDING = 2'd2;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_DROP, ST_PAD, ST_FCS, ST_PRE, ST_COMMIT
  } fsm_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // first payload byte accepted
    logic payWr;    // further payload byte accepted
    logic padWr;    // write one zero pad byte
    logic fcsWr;    // write one check byte
    logic preWr;    // write one preamble/delimiter byte
    logic tailClr;  // clear tail byte counter
    logic tailInc;  // advance tail byte counter
    logic slot;     // target slot of this write
  } strobe_t;

  function automatic logic [31:0] crcByte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] ^ d[k]) r = (r >> 1) ^ CRC_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxa_datapath.sv
module rxa_datapath
  import rxa_pkg::*;
#(
  parameter int BufBytes   = 2048,
  parameter int MinPayload = 60,
  parameter int NumSlots   = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [7:0]                    inData,
  output logic                          padNeeded,
  output logic                          atLimit,
  output logic                          fcsLast,
  output logic                          preLast,
  output logic [$clog2(BufBytes):0]     frameCount,
  output logic [NumSlots-1:0]           bufWe,
  output logic [$clog2(BufBytes)-1:0]   bufAddr,
  output logic [7:0]                    bufData
);
  localparam int AddrW      = $clog2(BufBytes);
  localparam int CntW       = AddrW + 1;
  localparam int PreLen     = 8;
  localparam int FcsLen     = 4;
  localparam int MaxPayload = BufBytes - PreLen - FcsLen;

  logic [CntW-1:0] payLen;
  logic [2:0]      tailCnt;
  logic [31:0]     crc;
  logic [31:0]     fcsWord;
  logic [7:0]      fcsByte;
  logic            wrAny;
  logic [CntW-1:0] wrOff;
  logic [7:0]      wrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      payLen  <= '0;
      crc     <= '1;
      tailCnt <= '0;
    end else begin
      if (stb.start) begin
        payLen <= CntW'(1);
        crc    <= crcByte(32'hFFFF_FFFF, inData);
      end else if (stb.payWr) begin
        payLen <= payLen + CntW'(1);
        crc    <= crcByte(crc, inData);
      end else if (stb.padWr) begin
        payLen <= payLen + CntW'(1);
        crc    <= crcByte(crc, 8'h00);
      end
      if (stb.start || stb.tailClr) tailCnt <= '0;
      else if (stb.tailInc)         tailCnt <= tailCnt + 3'd1;
    end
  end

  assign fcsWord = ~crc;
  assign fcsByte = fcsWord[{tailCnt[1:0], 3'b000} +: 8];

  always_comb begin
    wrAny  = stb.start | stb.payWr | stb.padWr | stb.fcsWr | stb.preWr;
    wrOff  = '0;
    wrByte = 8'h00;
    if (stb.start) begin
      wrOff  = CntW'(PreLen);
      wrByte = inData;
    end else if (stb.payWr) begin
      wrOff  = CntW'(PreLen) + payLen;
      wrByte = inData;
    end else if (stb.padWr) begin
      wrOff  = CntW'(PreLen) + payLen;
      wrByte = 8'h00;
    end else if (stb.fcsWr) begin
      wrOff  = CntW'(PreLen) + payLen + CntW'(tailCnt);
      wrByte = fcsByte;
    end else if (stb.preWr) begin
      wrOff  = CntW'(tailCnt);
      wrByte = (tailCnt == 3'(PreLen - 1)) ? SFD_BYTE : PRE_BYTE;
    end
  end

  for (genvar s = 0; s < NumSlots; s++) begin : g_we
    always_ff @(posedge clk) begin
      if (!rstN) bufWe[s] <= 1'b0;
      else       bufWe[s] <= wrAny && (int'(stb.slot) == s);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufAddr <= '0;
      bufData <= '0;
    end else if (wrAny) begin
      bufAddr <= wrOff[AddrW-1:0];
      bufData <= wrByte;
    end
  end

  assign padNeeded  = payLen < CntW'(MinPayload);
  assign atLimit    = payLen == CntW'(MaxPayload);
  assign fcsLast    = tailCnt == 3'(FcsLen - 1);
  assign preLast    = tailCnt == 3'(PreLen - 1);
  assign frameCount = payLen + CntW'(PreLen + FcsLen);

endmodule

// File: rtl/rxa_control.sv
module rxa_control
  import rxa_pkg::*;
#(
  parameter int BufBytes = 2048
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       inFirst,
  input  logic                       inLast,
  input  logic                       padNeeded,
  input  logic                       atLimit,
  input  logic                       fcsLast,
  input  logic                       preLast,
  input  logic [$clog2(BufBytes):0]  frameCount,
  input  logic                       regWrEn,
  input  logic [1:0]                 regAddr,
  input  logic [31:0]                regWrData,
  output logic [31:0]                regRdData,
  output logic                       rxIrq,
  output logic                       rxReady,
  output strobe_t                    stb
);
  localparam int CntW = $clog2(BufBytes) + 1;

  fsm_t            fsm, fsmNext;
  logic            selSlot;
  logic [1:0]      slotState [2];
  logic [CntW-1:0] slotCount [2];
  logic            anyLoaded;
  logic            pickSlot;
  logic            unusedWrBits;

  assign unusedWrBits = ^regWrData[31:CntW];
  assign anyLoaded = (slotState[0] == SLOT_LOADED) || (slotState[1] == SLOT_LOADED);
  assign pickSlot  = (slotState[0] != SLOT_LOADED);

  always_comb begin
    fsmNext  = fsm;
    stb      = '0;
    stb.slot = (fsm == ST_IDLE) ? pickSlot : selSlot;
    unique case (fsm)
      ST_IDLE: begin
        if (inValid && inFirst) begin
          if (anyLoaded) begin
            stb.start = 1'b1;
            fsmNext   = inLast ? ST_PAD : ST_RECV;
          end else begin
            fsmNext   = inLast ? ST_IDLE : ST_DROP;
          end
        end
      end
      ST_RECV: begin
        if (inValid) begin
          if (atLimit) begin
            fsmNext = inLast ? ST_IDLE : ST_DROP;
          end else begin
            stb.payWr = 1'b1;
            if (inLast) fsmNext = ST_PAD;
          end
        end
      end
      ST_DROP: begin
        if (inValid && inLast) fsmNext = ST_IDLE;
      end
      ST_PAD: begin
        if (padNeeded) stb.padWr = 1'b1;
        else           fsmNext   = ST_FCS;
      end
      ST_FCS: begin
        stb.fcsWr = 1'b1;
        if (fcsLast) begin
          stb.tailClr = 1'b1;
          fsmNext     = ST_PRE;
        end else begin
          stb.tailInc = 1'b1;
        end
      end
      ST_PRE: begin
        stb.preWr   = 1'b1;
        stb.tailInc = 1'b1;
        if (preLast) fsmNext = ST_COMMIT;
      end
      ST_COMMIT: fsmNext = ST_IDLE;
      default:   fsmNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsm     <= ST_IDLE;
      selSlot <= 1'b0;
    end else begin
      fsm <= fsmNext;
      if (stb.start) selSlot <= pickSlot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++) begin
        slotState[s] <= SLOT_EMPTY;
        slotCount[s] <= '0;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (regWrEn && regAddr == {s[0], 1'b0}) slotState[s] <= regWrData[1:0];
        if (regWrEn && regAddr == {s[0], 1'b1}) slotCount[s] <= regWrData[CntW-1:0];
        // hardware commit takes precedence over a same-cycle software write
        if (fsm == ST_COMMIT && selSlot == s[0]) begin
          slotState[s] <= SLOT_PENDING;
          slotCount[s] <= frameCount;
        end
      end
    end
  end

  always_comb begin
    if (regAddr[0]) regRdData = 32'(slotCount[regAddr[1]]);
    else            regRdData = 32'(slotState[regAddr[1]]);
  end

  assign rxIrq   = (slotState[0] == SLOT_PENDING) || (slotState[1] == SLOT_PENDING);
  assign rxReady = (fsm == ST_IDLE) && anyLoaded;

endmodule

// File: rtl/rx_frame_assembler.sv
module rx_frame_assembler
  import rxa_pkg::*;
#(
  parameter int BufBytes   = 2048,
  parameter int MinPayload = 60
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic                         inFirst,
  input  logic                         inLast,
  input  logic [7:0]                   inData,
  output logic                         buf0WrEn,
  output logic [$clog2(BufBytes)-1:0]  buf0Addr,
  output logic [7:0]                   buf0Data,
  output logic                         buf1WrEn,
  output logic [$clog2(BufBytes)-1:0]  buf1Addr,
  output logic [7:0]                   buf1Data,
  input  logic                         regWrEn,
  input  logic [1:0]                   regAddr,
  input  logic [31:0]                  regWrData,
  output logic [31:0]                  regRdData,
  output logic                         rxIrq,
  output logic                         rxReady
);
  localparam int AddrW = $clog2(BufBytes);
  localparam int CntW  = AddrW + 1;

  strobe_t         stb;
  logic            padNeeded, atLimit, fcsLast, preLast;
  logic [CntW-1:0] frameCount;
  logic [1:0]      bufWe;
  logic [AddrW-1:0] bufAddr;
  logic [7:0]      bufData;

  rxa_control #(.BufBytes(BufBytes)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .padNeeded(padNeeded), .atLimit(atLimit), .fcsLast(fcsLast), .preLast(preLast),
    .frameCount(frameCount),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxIrq(rxIrq), .rxReady(rxReady), .stb(stb)
  );

  rxa_datapath #(.BufBytes(BufBytes), .MinPayload(MinPayload), .NumSlots(2)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData),
    .padNeeded(padNeeded), .atLimit(atLimit), .fcsLast(fcsLast), .preLast(preLast),
    .frameCount(frameCount), .bufWe(bufWe), .bufAddr(bufAddr), .bufData(bufData)
  );

  assign buf0WrEn = bufWe[0];
  assign buf1WrEn = bufWe[1];
  assign buf0Addr = bufAddr;
  assign buf1Addr = bufAddr;
  assign buf0Data = bufData;
  assign buf1Data = bufData;

endmodule

// File: rtl/rx_frame_assembler_chk.sv
module rx_frame_assembler_chk #(
  parameter int AddrW = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             buf0WrEn,
  input logic             buf1WrEn,
  input logic [AddrW-1:0] bufAddr,
  input logic [7:0]       bufData,
  input logic             regWrEn,
  input logic             rxIrq,
  input logic             rxReady
);
  a_r11_one_port: assert property (@(posedge clk) disable iff (!rstN)
    !(buf0WrEn && buf1WrEn));

  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |-> !(buf0WrEn || buf1WrEn));

  a_r4_preamble: assert property (@(posedge clk) disable iff (!rstN)
    ((buf0WrEn || buf1WrEn) && bufAddr < AddrW'(7)) |-> bufData == 8'h55);

  a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxIrq) |-> $past(regWrEn));

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxIrq) |-> ($past(regWrEn) || $past(buf0WrEn || buf1WrEn)));
endmodule

bind rx_frame_assembler rx_frame_assembler_chk #(.AddrW($clog2(BufBytes))) u_chk (
  .clk(clk), .rstN(rstN), .buf0WrEn(buf0WrEn), .buf1WrEn(buf1WrEn),
  .bufAddr(buf0Addr), .bufData(buf0Data), .regWrEn(regWrEn),
  .rxIrq(rxIrq), .rxReady(rxReady)
);

// File: tb/test_rx_frame_assembler.sv
module test_rx_frame_assembler;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic buf0WrEn, buf1WrEn;
  logic [10:0] buf0Addr, buf1Addr;
  logic [7:0] buf0Data, buf1Data;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic rxIrq, rxReady;

  always #2 clk = ~clk;

  rx_frame_assembler i_rx_frame_assembler (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst), .inLast(inLast),
    .inData(inData), .buf0WrEn(buf0WrEn), .buf0Addr(buf0Addr), .buf0Data(buf0Data),
    .buf1WrEn(buf1WrEn), .buf1Addr(buf1Addr), .buf1Data(buf1Data),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .rxIrq(rxIrq), .rxReady(rxReady)
  );

  int nCmp = 0, nBad = 0;
  int wr0Cnt = 0, wr1Cnt = 0;
  bit done = 0;
  logic [7:0] mem0 [2048];
  logic [7:0] mem1 [2048];
  logic [7:0] expB [2048];
  int sbq [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: capture writes, compare frame image at the delimiter write
  always @(negedge clk) begin
    if (rstN && buf0WrEn) begin mem0[buf0Addr] = buf0Data; wr0Cnt++; end
    if (rstN && buf1WrEn) begin mem1[buf1Addr] = buf1Data; wr1Cnt++; end
    if (rstN && (buf0WrEn || buf1WrEn) && buf0Addr == 11'd7) begin
      if (sbq.size() == 0) begin
        chk("R3 unexpected frame completion", 1, 0);
      end else begin
        int e, slot, len, bad;
        e = sbq.pop_front();
        slot = e / 4096;
        len = e % 4096;
        chk("R11 write port of selected slot", buf1WrEn ? 1 : 0, slot);
        bad = 0;
        for (int i = 0; i < len; i++) begin
          logic [7:0] got;
          got = (slot == 1) ? mem1[i] : mem0[i];
          if (got !== expB[i]) begin
            if (bad == 0)
              $display("FAIL R4 R5 R6 byte %0d actual=%0h expected=%0h", i, got, expB[i]);
            bad++;
          end
        end
        nCmp++;
        if (bad != 0) nBad++;
      end
    end
  end

  function automatic logic [7:0] payByte(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + i / 5) & 255);
  endfunction

  task automatic buildExp(input int len, input int seed, output int total);
    int padLen;
    logic [31:0] c;
    padLen = (len < 60) ? 60 : len;
    for (int i = 0; i < 7; i++) expB[i] = 8'h55;
    expB[7] = 8'hD5;
    for (int i = 0; i < padLen; i++) expB[8 + i] = (i < len) ? payByte(seed, i) : 8'h00;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < padLen; i++)
      for (int k = 0; k < 8; k++)
        c = ((c[0] ^ expB[8 + i][k]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    c = ~c;
    for (int k = 0; k < 4; k++) expB[8 + padLen + k] = c[8*k +: 8];
    total = padLen + 12;
  endtask

  // expSlot: 0/1 expected target, -1 drop, -2 oversize
  task automatic sendFrame(input int len, input int seed, input int expSlot);
    int total;
    if (expSlot >= 0) begin
      buildExp(len, seed, total);
      sbq.push_back(expSlot * 4096 + total);
    end
    for (int i = 0; i < len; i++) begin
      if (i % 13 == 12) begin
        @(negedge clk); inValid = 1'b0;
      end
      @(negedge clk);
      inValid = 1'b1; inFirst = (i == 0); inLast = (i == len - 1);
      inData = payByte(seed, i);
    end
    @(negedge clk);
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0;
    if (expSlot >= 0) chk("R10 not ready while assembling", rxReady, 0);
    repeat (90) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic chkReg(input string req, input logic [1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkReg("R1 state0", 2'd0, 0);
    chkReg("R1 count0", 2'd1, 0);
    chkReg("R1 state1", 2'd2, 0);
    chkReg("R1 count1", 2'd3, 0);
    chk("R1 rxIrq", rxIrq, 0);
    chk("R1 rxReady", rxReady, 0);

    // R3: no slot loaded -> drop
    w = wr0Cnt + wr1Cnt;
    sendFrame(30, 1, -1);
    chk("R3 no writes without loaded slot", wr0Cnt + wr1Cnt, w);
    chkReg("R3 state0 unchanged", 2'd0, 0);
    chkReg("R3 count0 unchanged", 2'd1, 0);

    // load both
    wrReg(2'd0, 1);
    wrReg(2'd2, 1);
    chk("R10 ready with loaded slot", rxReady, 1);

    sendFrame(20, 2, 0);
    chkReg("R7 R5 count0 padded", 2'd1, 72);
    chkReg("R7 state0 pending", 2'd0, 2);
    chkReg("R2 state1 untouched", 2'd2, 1);
    chk("R9 irq with pending slot", rxIrq, 1);

    sendFrame(100, 3, 1);
    chkReg("R7 count1", 2'd3, 112);
    chkReg("R7 state1 pending", 2'd2, 2);
    chk("R10 not ready when both pending", rxReady, 0);

    w = wr0Cnt + wr1Cnt;
    sendFrame(40, 4, -1);
    chk("R3 no writes when both pending", wr0Cnt + wr1Cnt, w);
    chkReg("R3 count0 kept", 2'd1, 72);
    chkReg("R3 count1 kept", 2'd3, 112);

    wrReg(2'd0, 0);
    chk("R9 irq held by slot1", rxIrq, 1);
    wrReg(2'd2, 0);
    chk("R9 irq low with none pending", rxIrq, 0);

    // R2 priority: both loaded -> slot 0
    wrReg(2'd2, 1);
    wrReg(2'd0, 1);
    sendFrame(60, 5, 0);
    chkReg("R5 sixty bytes not padded", 2'd1, 72);
    chkReg("R2 slot1 still loaded", 2'd2, 1);

    // single-byte frame goes to slot 1
    sendFrame(1, 6, 1);
    chkReg("R5 single byte padded", 2'd3, 72);
    chkReg("R2 slot1 pending", 2'd2, 2);

    // R8 oversize
    wrReg(2'd0, 1);
    sendFrame(2037, 7, -2);
    chkReg("R8 state0 unchanged on oversize", 2'd0, 1);
    chkReg("R8 count0 unchanged on oversize", 2'd1, 72);

    sendFrame(2036, 8, 0);
    chkReg("R8 largest frame count", 2'd1, 2048);
    chkReg("R8 largest frame state", 2'd0, 2);
    chk("R7 scoreboard drained", sbq.size(), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule